// File: doc/BRIEF.md
# Lanewise SIMD Integer Arithmetic Unit

This unit takes two 128-bit vector operands and applies one element-wise operation to them. The vector is split into equal lanes of 8, 16 or 32 bits, selected per request. The operations are add, subtract, multiply, equality compare, bit-test, absolute value and negate. Compare and test results are full-lane masks, so they can feed a select or blend step directly.

Absolute value and negate also have a float mode. In that mode the unit touches only the sign bit of each 32-bit word, which is enough for single-precision values without any floating-point hardware.

A request is presented with a one-cycle valid strobe. The result and an unsupported flag appear on the next cycle, together with an output-valid strobe. Both are held until the next request.

Top module: `lane_simd_alu`

## Requirements
- R1: `lane_sz` selects the lane width: 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes and 2 gives four 32-bit lanes. Lane 0 occupies the least significant bits.
- R2: Add (`op_sel`=0) and subtract (`op_sel`=1) wrap modulo the lane width. No carry or borrow crosses a lane boundary.
- R3: Multiply (`op_sel`=2) writes the low lane-width bits of each lane's product.
- R4: Equality compare (`op_sel`=3) writes all ones into a lane whose two inputs are equal, and zero otherwise.
- R5: Bit-test (`op_sel`=4) writes all ones into a lane when the AND of its two inputs is nonzero, and zero otherwise.
- R6: With `fp_mode`=0, absolute value (`op_sel`=5) and negate (`op_sel`=6) treat lanes as signed two's complement. The most negative lane value maps to itself. Operand B is ignored.
- R7: With `fp_mode`=1, absolute value clears bit 31 of every 32-bit word and negate inverts it. All other bits pass unchanged, and `lane_sz` has no effect, including the value 3.
- R8: `lane_sz`=3 on any integer operation, or `op_sel`=7, raises `unsupported` and gives a zero result. `fp_mode` has no effect on operations other than absolute value and negate.
- R9: After reset, `out_valid`, `result` and `unsupported` are zero. A request with `in_valid` high gives `out_valid` high with its result and flag on the next cycle. Without a request, `out_valid` is low and `result` and `unsupported` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opnd_a | input | 128 | First vector operand |
| opnd_b | input | 128 | Second vector operand |
| lane_sz | input | 2 | Lane width code |
| op_sel | input | 3 | Operation code |
| fp_mode | input | 1 | Sign-bit float mode for abs/neg |
| out_valid | output | 1 | Result strobe, one cycle after a request |
| result | output | 128 | Registered vector result |
| unsupported | output | 1 | Request used an unsupported size or op |

## Verification
Random operand pairs run across all sizes, op codes and mode settings. Some operand B values are copies of A or share single lanes with it, so that compare and test produce both mask polarities within one vector. Directed vectors place all-ones lanes against ones, which exposes any carry that leaks across a boundary at each width. Most-negative lanes check that abs and neg wrap back to the same value. Float-mode vectors with size code 3 separate the sign-bit path from the unsupported path. An idle cycle after each request shows that the output holds.

// File: rtl/lane_simd_pkg.sv
// Shared types for the lanewise SIMD unit: operation and lane-size codes.
package lane_simd_pkg;
    localparam int VEC_W = 128;
    localparam int FLT_W = 32;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_CEQ  = 3'd3,
        OP_TST  = 3'd4,
        OP_ABS  = 3'd5,
        OP_NEG  = 3'd6,
        OP_RSVD = 3'd7
    } simd_op_e;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B64 = 2'd3
    } simd_sz_e;
endpackage

// File: rtl/simd_lane_bank.sv
// Applies one integer operation to every lane of a fixed width in parallel.
// Assumes VEC_W is a multiple of LANE_W. Lanes are independent, so no carry crosses them.
module simd_lane_bank
    import lane_simd_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  simd_op_e         op,
    output logic [VEC_W-1:0] y
);
    localparam int NLANES = VEC_W / LANE_W;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [LANE_W-1:0] la, lb, ly;
        assign la = a[g*LANE_W +: LANE_W];
        assign lb = b[g*LANE_W +: LANE_W];

        // Per-lane operation select; all arithmetic wraps at LANE_W bits.
        always_comb begin
            case (op)
                OP_ADD:  ly = la + lb;
                OP_SUB:  ly = la - lb;
                OP_MUL:  ly = la * lb;
                OP_CEQ:  ly = (la == lb) ? '1 : '0;
                OP_TST:  ly = (|(la & lb)) ? '1 : '0;
                OP_ABS:  ly = la[LANE_W-1] ? (~la + 1'b1) : la;
                OP_NEG:  ly = ~la + 1'b1;
                default: ly = '0;
            endcase
        end

        assign y[g*LANE_W +: LANE_W] = ly;
    end
endmodule

// File: rtl/simd_sign_unit.sv
// Float-mode abs/neg: clears or inverts the top bit of each FLT_W-bit word.
// Assumes VEC_W is a multiple of FLT_W. Every other bit passes through.
module simd_sign_unit #(
    parameter int VEC_W = 128,
    parameter int FLT_W = 32
) (
    input  logic [VEC_W-1:0] a,
    input  logic             invert,
    output logic [VEC_W-1:0] y
);
    localparam int NWORDS = VEC_W / FLT_W;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [FLT_W-1:0] w;
        assign w = a[g*FLT_W +: FLT_W];
        // Sign bit either cleared (abs) or flipped (neg); magnitude untouched.
        assign y[g*FLT_W +: FLT_W] = {invert & ~w[FLT_W-1], w[FLT_W-2:0]};
    end
endmodule

// File: rtl/simd_out_reg.sv
// Output stage: captures result and flag on a request and pulses valid.
// Holds its contents while no request is presented.
module simd_out_reg #(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] d,
    input  logic             d_unsup,
    output logic [VEC_W-1:0] q,
    output logic             q_unsup,
    output logic             q_vld
);
    // Register the data and flag only on a request; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q_unsup <= 1'b0;
            q_vld   <= 1'b0;
        end else begin
            q_vld <= load;
            if (load) begin
                q       <= d;
                q_unsup <= d_unsup;
            end
        end
    end
endmodule

// File: rtl/lane_simd_alu.sv
// Top of the lanewise SIMD unit. It runs one lane bank per supported width
// and one sign-bit path, then selects one of them and registers it.
// Assumes the request is a single-cycle strobe. There is no backpressure.
module lane_simd_alu
    import lane_simd_pkg::*;
#(
    parameter int VEC_W = lane_simd_pkg::VEC_W,
    parameter int FLT_W = lane_simd_pkg::FLT_W,
    parameter int NSIZE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    input  logic [1:0]       lane_sz,
    input  logic [2:0]       op_sel,
    input  logic             fp_mode,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             unsupported
);
    simd_op_e         op;
    simd_sz_e         sz;
    logic [VEC_W-1:0] bank_y [NSIZE];
    logic [VEC_W-1:0] sign_y;
    logic [VEC_W-1:0] next_y;
    logic             fp_path;
    logic             next_unsup;

    assign op = simd_op_e'(op_sel);
    assign sz = simd_sz_e'(lane_sz);

    // One bank per lane width: 8, 16, 32 bits.
    for (genvar s = 0; s < NSIZE; s++) begin : g_bank
        simd_lane_bank #(.VEC_W(VEC_W), .LANE_W(8 << s)) u_bank (
            .a  (opnd_a),
            .b  (opnd_b),
            .op (op),
            .y  (bank_y[s])
        );
    end

    simd_sign_unit #(.VEC_W(VEC_W), .FLT_W(FLT_W)) u_sign (
        .a      (opnd_a),
        .invert (op == OP_NEG),
        .y      (sign_y)
    );

    // Pick the float path, the unsupported zero, or the bank for this width.
    always_comb begin
        fp_path    = fp_mode && (op == OP_ABS || op == OP_NEG);
        next_unsup = !fp_path && (sz == SZ_B64 || op == OP_RSVD);
        if (fp_path) begin
            next_y = sign_y;
        end else if (next_unsup) begin
            next_y = '0;
        end else begin
            case (sz)
                SZ_B8:   next_y = bank_y[0];
                SZ_B16:  next_y = bank_y[1];
                default: next_y = bank_y[2];
            endcase
        end
    end

    simd_out_reg #(.VEC_W(VEC_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (next_y),
        .d_unsup (next_unsup),
        .q       (result),
        .q_unsup (unsupported),
        .q_vld   (out_valid)
    );
endmodule

// File: rtl/lane_simd_alu_chk.sv
// Checker for lane_simd_alu: port-level timing and mode properties.
module lane_simd_alu_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VEC_W-1:0] opnd_a,
    input logic [1:0]       lane_sz,
    input logic [2:0]       op_sel,
    input logic             fp_mode,
    input logic             out_valid,
    input logic [VEC_W-1:0] result,
    input logic             unsupported
);
    localparam logic [VEC_W-1:0] SIGN_MASK = {(VEC_W/32){32'h8000_0000}};

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(unsupported)));

    a_r8_unsup_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && unsupported) |-> (result == '0));

    a_r8_size_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sz == 2'd3 && !fp_mode) |=> unsupported);

    a_r7_float_abs: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fp_mode && op_sel == 3'd5) |=>
            (!unsupported && result == ($past(opnd_a) & ~SIGN_MASK)));

    a_r7_float_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fp_mode && op_sel == 3'd6) |=>
            (result == ($past(opnd_a) ^ SIGN_MASK)));
endmodule

bind lane_simd_alu lane_simd_alu_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .opnd_a      (opnd_a),
    .lane_sz     (lane_sz),
    .op_sel      (op_sel),
    .fp_mode     (fp_mode),
    .out_valid   (out_valid),
    .result      (result),
    .unsupported (unsupported)
);

// File: tb/lane_simd_alu_test.sv
// Self-checking bench: directed corners plus seeded random requests.
module lane_simd_alu_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic [1:0]   lane_sz = '0;
    logic [2:0]   op_sel = '0;
    logic         fp_mode = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic         unsupported;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lane_simd_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .lane_sz(lane_sz),
        .op_sel(op_sel), .fp_mode(fp_mode), .out_valid(out_valid),
        .result(result), .unsupported(unsupported)
    );

    // Expected {unsupported, result} computed from the requirements.
    function automatic logic [128:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [1:0] sz, input logic [2:0] op,
                                           input logic fp);
        logic [127:0] r;
        logic [31:0]  m, x, y, z;
        int lw;
        r = '0;
        if (fp && (op == 3'd5 || op == 3'd6)) begin
            for (int i = 0; i < 4; i++) begin
                x = a[i*32 +: 32];
                if (op == 3'd5) x[31] = 1'b0;
                else            x[31] = ~x[31];
                r[i*32 +: 32] = x;
            end
            return {1'b0, r};
        end
        if (sz == 2'd3 || op == 3'd7) return {1'b1, 128'b0};
        lw = 8 << sz;
        m  = (lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 32'd1);
        for (int i = 0; i < 128 / lw; i++) begin
            x = 32'(a >> (i * lw)) & m;
            y = 32'(b >> (i * lw)) & m;
            case (op)
                3'd0: z = x + y;
                3'd1: z = x - y;
                3'd2: z = x * y;
                3'd3: z = (x == y) ? m : 32'd0;
                3'd4: z = ((x & y) != 0) ? m : 32'd0;
                3'd5: z = x[lw-1] ? (32'd0 - x) : x;
                default: z = 32'd0 - x;
            endcase
            z = z & m;
            r = r | (128'(z) << (i * lw));
        end
        return {1'b0, r};
    endfunction

    task automatic check(input bit ok, input string req, input logic [128:0] act,
                         input logic [128:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request, then compare outputs at the following falling edge.
    task automatic run(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                       input logic [2:0] op, input logic fp, input string req);
        logic [128:0] exp;
        exp = model(a, b, sz, op, fp);
        @(negedge clk);
        opnd_a = a; opnd_b = b; lane_sz = sz; op_sel = op; fp_mode = fp;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && {unsupported, result} == exp, req,
              {unsupported, result}, exp);
    endtask

    initial begin
        logic [128:0] held;
        logic [127:0] ra, rb;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!out_valid && result == '0 && !unsupported, "R9 reset",
              {unsupported, result}, '0);
        rst_n = 1'b1;

        // R2: carries must not leak across lane boundaries at any width
        run({16{8'hFF}}, {16{8'h01}}, 2'd0, 3'd0, 1'b0, "R2 add8 wrap");
        run({8{16'hFFFF}}, {8{16'h0001}}, 2'd1, 3'd0, 1'b0, "R2 add16 wrap");
        run('0, {4{32'h0000_0001}}, 2'd2, 3'd1, 1'b0, "R2 sub32 borrow");
        // R1: lane ordering, distinct lanes
        run(128'h0F0E0D0C0B0A09080706050403020100, {16{8'h10}}, 2'd0, 3'd0, 1'b0, "R1 lane order");
        // R3: multiply keeps low bits
        run({4{32'h1234_5678}}, {4{32'h9ABC_DEF1}}, 2'd2, 3'd2, 1'b0, "R3 mul32");
        run({8{16'h8001}}, {8{16'h0003}}, 2'd1, 3'd2, 1'b0, "R3 mul16");
        // R4, R5: masks of both polarities
        run(128'h00112233445566778899AABBCCDDEEFF, 128'h00112233005566778899AABB00DDEEFF,
            2'd1, 3'd3, 1'b0, "R4 ceq16");
        run({8{16'h00F0}}, {4{32'h0010_0F0F}}, 2'd1, 3'd4, 1'b0, "R5 tst16");
        // R6: most negative value maps to itself
        run({16{8'h80}}, '0, 2'd0, 3'd5, 1'b0, "R6 abs8 min");
        run({4{32'h8000_0000}}, '0, 2'd2, 3'd6, 1'b0, "R6 neg32 min");
        run({8{16'hFFFE}}, {8{16'h1234}}, 2'd1, 3'd5, 1'b0, "R6 abs16");
        // R7: float mode ignores size, even code 3
        run({4{32'hBF80_0000}}, '0, 2'd3, 3'd5, 1'b1, "R7 fabs sz3");
        run({4{32'h3F80_0000}}, '0, 2'd0, 3'd6, 1'b1, "R7 fneg");
        // R8: unsupported size and op, fp_mode ignored for add
        run({16{8'h55}}, {16{8'h22}}, 2'd3, 3'd0, 1'b0, "R8 size3");
        run({16{8'h55}}, {16{8'h22}}, 2'd0, 3'd7, 1'b1, "R8 op7");
        run({16{8'h55}}, {16{8'h22}}, 2'd0, 3'd0, 1'b1, "R8 fp add");

        // R9: hold while idle
        held = {unsupported, result};
        @(negedge clk);
        check(!out_valid && {unsupported, result} == held, "R9 hold",
              {unsupported, result}, held);

        // Random mix, all requirements
        for (int k = 0; k < 400; k++) begin
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(0, 3) == 0) rb = ra;
            else if ($urandom_range(0, 2) == 0) rb = ra ^ (rb & {4{32'h0000_FF00}});
            run(ra, rb, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                1'($urandom_range(0, 1)), "R1-random R2 R3 R4 R5 R6 R7 R8");
        end
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule